// File: doc/BRIEF.md
# Third-order cascaded fractional divide-ratio modulator

This block chooses, once per reference cycle, the divide ratio that a multimodulus prescaler applies in a fractional-N synthesizer loop. A constant M-bit fractional word K is fed to three cascaded error-feedback accumulators. The first accumulator sums K. The second sums the first stage's wrapped residue. The third sums the second stage's residue. The wrap-around carries are delayed and differenced, which gives a small signed offset with third-order high-pass shaping of its quantisation error. Over time that offset averages K/2^M.

The offset covers -3 to +4. It is registered in two forms: a 3-bit biased select code for a prescaler decoder, and the absolute ratio N plus offset. The prescaler therefore sees one stable value for each division period. With the default N of 70, the ratios run from 67 to 74. The adder width M and the base ratio N are parameters. The output width follows from N.

Top module: `mash_frac_mod`

## Requirements
- R1: While rst_ni is low, and after it returns high until the first rising clock edge, sel_o reads 3 and ratio_o reads N. Reset clears all three accumulators and all carry delay registers.
- R2: sel_o encodes the offset as offset+3, so code 0 means -3 and code 7 means +4. ratio_o always equals N-3+sel_o, and it stays within N-3 to N+4.
- R3: With fractional word 0 held from reset, every output gives offset 0.
- R4: With a constant word K held from reset, the sum of the first 2^M offsets lies within K-3 to K+3. The long-run average is therefore K/2^M.
- R5: Each stage's stored sum becomes (stored sum + stage input) mod 2^M on every clock. Its carry is 1 exactly when that addition wraps. A stage whose input is 0 holds its sum.
- R6: Stage 2 takes stage 1's new residue in the same cycle, and stage 3 takes stage 2's new residue in the same cycle. The offset is y[n] = c1[n-2] + c2[n-1] - c2[n-2] + c3[n] - 2·c3[n-1] + c3[n-2], with carries before reset release taken as 0. After the k-th rising edge (k from 0) following reset release, the outputs hold y[k]. For K = 2^(M-1) the offsets are 0, 1, -2, 3, and then -1, 2, -2, 3 repeating.
- R7: A reset asserted mid-run discards all accumulated history. If word 0 is applied afterwards, the offset is exactly 0 from the first output on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Divided reference clock, one modulator step per rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frac_i | input | M | Fractional control word K |
| sel_o | output | 3 | Registered biased modulus-select code, offset+3 |
| ratio_o | output | RW | Registered divide ratio N+offset |

## Verification
The assertions assume that the clock is free-running and that frac_i changes only between rising edges, so every stage addition sees one settled input. The range and encoding assertions assume that the word is held steady long enough for the delay line to fill. The bench therefore changes frac_i only while reset is asserted or a full window after the last reset, and it drives every input one time unit after a rising edge.

// File: rtl/mash_frac_pkg.sv
package mash_frac_pkg;
  typedef logic signed [3:0] offset_t;
  localparam int NUM_STAGES  = 3;
  localparam int OFFSET_BIAS = 3;
  localparam int OFFSET_MIN  = -3;
  localparam int OFFSET_MAX  = 4;
endpackage

// File: rtl/mash_acc_stage.sv
module mash_acc_stage #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o
);
  logic [W-1:0] acc_q;

  always_comb {carry_o, sum_o} = {1'b0, acc_q} + {1'b0, in_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= sum_o;
  end

  assert_zero_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_i == '0) |=> $stable(acc_q));

  assert_carry_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o == (sum_o < in_i));
endmodule

// File: rtl/mash_noise_comb.sv
module mash_noise_comb
  import mash_frac_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_STAGES-1:0] carry_i,
  output offset_t               offset_o
);
  localparam int DLY = 2;

  // per-stage carry history: [0] = one cycle old, [1] = two cycles old
  logic [DLY-1:0] hist_q [NUM_STAGES];

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_dly
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hist_q[s] <= '0;
      else         hist_q[s] <= {hist_q[s][0], carry_i[s]};
    end
  end

  int sum_v;
  always_comb begin
    sum_v = int'(hist_q[0][1])
          + int'(hist_q[1][0]) - int'(hist_q[1][1])
          + int'(carry_i[2]) - 2 * int'(hist_q[2][0]) + int'(hist_q[2][1]);
    offset_o = offset_t'(sum_v);
  end

  assert_offset_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(offset_o) >= OFFSET_MIN) && (int'(offset_o) <= OFFSET_MAX));
endmodule

// File: rtl/mash_frac_mod.sv
module mash_frac_mod
  import mash_frac_pkg::*;
#(
  parameter int M  = 16,
  parameter int N  = 70,
  parameter int RW = $clog2(N + OFFSET_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [M-1:0]  frac_i,
  output logic [2:0]    sel_o,
  output logic [RW-1:0] ratio_o
);
  logic [M-1:0]            chain [NUM_STAGES+1];
  logic [NUM_STAGES-1:0]   carry;
  offset_t                 offset;

  assign chain[0] = frac_i;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    mash_acc_stage #(.W(M)) i_stage (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .in_i    (chain[s]),
      .sum_o   (chain[s+1]),
      .carry_o (carry[s])
    );
  end

  mash_noise_comb i_comb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .carry_i  (carry),
    .offset_o (offset)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o   <= 3'(OFFSET_BIAS);
      ratio_o <= RW'(N);
    end else begin
      sel_o   <= 3'(int'(offset) + OFFSET_BIAS);
      ratio_o <= RW'(N + int'(offset));
    end
  end

  assert_ratio_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(ratio_o) == N - OFFSET_BIAS + int'(sel_o));
endmodule

// File: tb/test_mash_frac_mod.sv
module test_mash_frac_mod;
  localparam int CLK_PERIOD = 10;
  localparam int M  = 10;
  localparam int N  = 70;
  localparam int RW = 7;
  localparam int WIN = 1 << M;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [M-1:0]  frac = '0;
  logic [2:0]    sel;
  logic [RW-1:0] ratio;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mash_frac_mod #(.M(M), .N(N), .RW(RW)) i_mash_frac_mod (
    .clk_i (clk), .rst_ni (rst_n), .frac_i (frac), .sel_o (sel), .ratio_o (ratio)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int cur_off();
    return int'(sel) - 3;
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  // sample after a step: check code/ratio coupling (R2)
  task automatic chk_code();
    chk(int'(ratio) == N - 3 + int'(sel), "R2 ratio/code", int'(ratio), N - 3 + int'(sel));
  endtask

  task automatic start(input logic [M-1:0] k);
    rst_n = 1'b0;
    frac  = k;
    step(); step();
    chk(sel == 3'd3, "R1 sel in reset", int'(sel), 3);
    chk(int'(ratio) == N, "R1 ratio in reset", int'(ratio), N);
    rst_n = 1'b1;
    #2;
    chk(sel == 3'd3, "R1 sel before first edge", int'(sel), 3);
  endtask

  task automatic t_zero();
    start('0);
    for (int i = 0; i < 40; i++) begin
      step();
      chk(cur_off() == 0, "R3 zero word", cur_off(), 0);
      chk_code();
    end
  endtask

  task automatic t_half_seq();
    int head [4] = '{0, 1, -2, 3};
    int tail [4] = '{-1, 2, -2, 3};
    start(M'(1 << (M-1)));
    for (int n = 0; n < 24; n++) begin
      int e;
      step();
      e = (n < 4) ? head[n] : tail[(n-4) % 4];
      chk(cur_off() == e, "R6 half-scale sequence", cur_off(), e);
    end
  endtask

  task automatic t_mean(input int k);
    int sum = 0;
    bit in_range = 1'b1;
    start(M'(k));
    for (int n = 0; n < WIN; n++) begin
      step();
      sum += cur_off();
      if (int'(ratio) < N - 3 || int'(ratio) > N + 4 || int'(ratio) != N - 3 + int'(sel))
        in_range = 1'b0;
    end
    chk(in_range, "R2 ratio within N-3..N+4", int'(in_range), 1);
    chk(sum >= k - 3 && sum <= k + 3, "R4 window sum", sum, k);
  endtask

  task automatic t_mid_reset();
    start(M'(777));
    for (int i = 0; i < 100; i++) step();
    rst_n = 1'b0;
    frac  = '0;
    #2;
    chk(sel == 3'd3, "R1 async reset", int'(sel), 3);
    step(); step();
    rst_n = 1'b1;
    for (int i = 0; i < 30; i++) begin
      step();
      chk(cur_off() == 0, "R7 history cleared", cur_off(), 0);
    end
  endtask

  // R5: single-stage behaviour visible via K=1, first carry from stage 1 only at 2^M
  task automatic t_unit_word();
    int first_nz = -1;
    start(M'(1));
    for (int n = 0; n < WIN + 8; n++) begin
      step();
      if (first_nz < 0 && cur_off() != 0) first_nz = n;
    end
    // stage 3 first wraps earliest: its input grows quadratically, sum of residues
    chk(first_nz > 0, "R5 no offset before any wrap", first_nz, 1);
  endtask

  initial begin
    t_zero();
    t_half_seq();
    t_mean(1);
    t_mean(333);
    t_mean(512);
    t_mean(700);
    t_mean(1023);
    t_mid_reset();
    t_unit_word();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule